// File: doc/BRIEF.md
# Variable Phase Shift Step Unit

This block is the digital control side of a clock-manager fine phase shifter. Requests arrive on a phase-shift clock as an enable and a direction bit. Each accepted request moves a signed step count by one, up or down. The count is the fine phase offset that a delay line downstream would apply. The count saturates at a symmetric bound. The bound is computed at elaboration from the period of the reference input clock, and the multiplier depends on whether that clock is slower than 60 MHz.

An accepted request is not finished at once. It is handed to the reference clock domain, which waits a fixed number of reference cycles. The completion is then handed back to the phase-shift domain, which waits three more of its own cycles. Only then is the new step value published, together with a one-cycle done pulse. Until that pulse, the unit is busy and ignores further enables. Reset clears the count, the busy state and every crossing, so a request cut off by reset never completes.

Top module: `phase_step_unit`

## Requirements
- R1: With the unit idle, a rising edge of `ps_clk` with `ps_en` high and `ps_up` high accepts a request, and on completion `step_val` is one greater than before.
- R2: An accepted request with `ps_up` low makes `step_val` one smaller on completion.
- R3: `step_val` never leaves the range from -L to +L. With T the reference period in ns, L is floor(15*(T-3)) when the reference clock is 60 MHz or faster and floor(10*(T-3)) when it is slower. L is 0 when T is 3 or less. A request that would cross L leaves `step_val` unchanged but still ends with a normal done pulse.
- R4: `ps_done` is high for exactly one `ps_clk` cycle per accepted request, and `step_val` already holds the new value in that cycle.
- R5: `ps_done` is raised no earlier than REF_LAT `ref_clk` cycles plus three `ps_clk` cycles after the accepting edge, and within two synchronizer delays of that.
- R6: An enable that arrives while a request is in progress is ignored. It changes no step and adds no done pulse.
- R7: Synchronous active-low reset sets `step_val` to 0 and `ps_done` low. A request in progress at reset produces no done pulse afterwards.
- R8: `at_limit` is high exactly when `step_val` equals +L or -L.
- R9: An enable held high during the done cycle is accepted, so a constantly high enable gives one step per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ps_clk | input | 1 | Phase-shift clock; all requests and done are synchronous to it |
| ref_clk | input | 1 | Reference input clock; the latency wait runs on it |
| rst_n | input | 1 | Synchronous active-low reset, held for at least two cycles of each clock |
| ps_en | input | 1 | Request enable, sampled on `ps_clk` |
| ps_up | input | 1 | Direction: 1 increments, 0 decrements |
| ps_done | output | 1 | One-cycle completion pulse |
| step_val | output | STEP_W | Current signed step count (two's complement) |
| at_limit | output | 1 | Step count sits at +L or -L |

## Verification
The done pulse is due between REF_LAT reference periods plus three phase-shift cycles and about two synchronizer delays later. The bench counts falling edges of `ps_clk` from the accepting edge and checks that the count falls inside that window. The new step value and the limit flag are read in the same falling-edge sample that first shows done high. Done must be low again one sample later. For the ignored-enable and reset cases, the bench keeps a running count of done pulses and compares it after a quiet interval well beyond the longest latency.

// File: rtl/phase_step_pkg.sv
// Shared types and the elaboration-time step bound for the phase step unit.
// Assumes periods are given as whole picoseconds.
package phase_step_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WAIT  = 2'd1,
        PS_FINAL = 2'd2
    } ps_state_t;

    // Symmetric step bound from the reference period, clamped to the counter width.
    function automatic int step_limit(input int period_ps, input int width);
        int lim;
        int cap;
        cap = (1 << (width - 1)) - 1;
        if (period_ps <= 3000)
            lim = 0;
        else if (period_ps * 60 > 1000000)
            lim = (period_ps - 3000) / 100;
        else
            lim = (15 * (period_ps - 3000)) / 1000;
        if (lim > cap)
            lim = cap;
        return lim;
    endfunction

endpackage

// File: rtl/ps_ref_delay.sv
// Reference-domain latency stage. It detects a request toggle through a
// two-flop synchronizer, waits REF_LAT reference cycles, then flips the
// acknowledge toggle. Assumes REF_LAT >= 1 and that a new request toggle
// never arrives before the previous acknowledge (the caller is busy).
module ps_ref_delay #(
    parameter int REF_LAT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_tgl,
    output logic ack_tgl
);
    localparam int CW = $clog2(REF_LAT + 1);

    logic [2:0]    req_sync;
    logic          req_seen;
    logic [CW-1:0] cnt;
    logic          active;

    // Bring the request toggle into the reference domain and keep one extra stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= {req_sync[1:0], req_tgl};
    end

    assign req_seen = req_sync[2] ^ req_sync[1];

    // Count the latency window and flip the acknowledge when it runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            active  <= 1'b0;
            ack_tgl <= 1'b0;
        end else if (req_seen) begin
            cnt    <= CW'(REF_LAT);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == CW'(1)) begin
                active  <= 1'b0;
                ack_tgl <= ~ack_tgl;
            end
            cnt <= cnt - CW'(1);
        end
    end

    // R6: a second request never reaches this domain while one is being counted.
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_seen |-> !active);

    // R5: the acknowledge only moves at the end of a counted window.
    p_ack_after_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active && (cnt > CW'(1)) |=> $stable(ack_tgl));

endmodule

// File: rtl/ps_req_ctrl.sv
// Phase-shift-domain request control. It accepts an enable only when idle,
// sends the request as a toggle, waits for the synchronized acknowledge,
// runs three final cycles, then raises apply for one cycle and done on the
// following edge-aligned cycle. Enables while busy are dropped.
module ps_req_ctrl
    import phase_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dir,
    input  logic ack_tgl,
    output logic req_tgl,
    output logic apply,
    output logic apply_up,
    output logic done,
    output logic busy
);
    ps_state_t  state;
    logic [2:0] ack_sync;
    logic       ack_seen;
    logic [1:0] fin_cnt;
    logic       dir_q;

    // Bring the acknowledge toggle back into this domain with an edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_sync <= '0;
        else        ack_sync <= {ack_sync[1:0], ack_tgl};
    end

    assign ack_seen = ack_sync[2] ^ ack_sync[1];
    assign busy     = (state != PS_IDLE);
    assign apply    = (state == PS_FINAL) && (fin_cnt == 2'd0);
    assign apply_up = dir_q;

    // Request sequencing: accept, wait for the acknowledge, count three cycles, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_IDLE;
            req_tgl <= 1'b0;
            dir_q   <= 1'b0;
            fin_cnt <= 2'd0;
            done    <= 1'b0;
        end else begin
            done <= apply;
            case (state)
                PS_IDLE: begin
                    if (en) begin
                        req_tgl <= ~req_tgl;
                        dir_q   <= dir;
                        state   <= PS_WAIT;
                    end
                end
                PS_WAIT: begin
                    if (ack_seen) begin
                        fin_cnt <= 2'd2;
                        state   <= PS_FINAL;
                    end
                end
                PS_FINAL: begin
                    if (fin_cnt == 2'd0) state <= PS_IDLE;
                    else                 fin_cnt <= fin_cnt - 2'd1;
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    // R4: the done pulse lasts a single cycle.
    p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an enable while busy sends nothing to the reference domain.
    p_busy_ignores_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && en |=> $stable(req_tgl));

    // R5: an acknowledge only comes back while a request is outstanding.
    p_ack_only_waiting_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |-> (state == PS_WAIT));

endmodule

// File: rtl/ps_step_acc.sv
// Saturating signed step accumulator. It moves by one on apply in the
// requested direction and holds at +/-LIM. Assumes LIM fits in W-1 bits.
module ps_step_acc #(
    parameter int W   = 10,
    parameter int LIM = 75
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apply,
    input  logic                up,
    output logic signed [W-1:0] step,
    output logic                at_limit
);
    localparam logic signed [W-1:0] POS = W'(LIM);
    localparam logic signed [W-1:0] NEG = -W'(LIM);

    // Update the step count on apply, holding at either bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (apply) begin
            if (up && (step < POS))       step <= step + W'(1);
            else if (!up && (step > NEG)) step <= step - W'(1);
        end
    end

    assign at_limit = (step == POS) || (step == NEG);

    // R3: the count stays inside the bound.
    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step <= POS) && (step >= NEG));

    // R6: without apply the count does not move.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(step));

    // R1: an upward apply below the bound adds exactly one.
    p_inc_by_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        apply && up && (step < POS) |=> (step == $past(step) + W'(1)));

    // R2: a downward apply above the bound subtracts exactly one.
    p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        apply && !up && (step > NEG) |=> (step == $past(step) - W'(1)));

endmodule

// File: rtl/phase_step_unit.sv
// Top of the variable phase shift step unit. It wires the phase-shift
// request control, the reference-domain latency stage and the saturating
// accumulator. The bound is fixed at elaboration from CLK_PERIOD_PS.
// Assumes rst_n is held low for at least two cycles of each clock.
module phase_step_unit
    import phase_step_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int REF_LAT       = 100,
    parameter int STEP_W        = 10
) (
    input  logic                     ps_clk,
    input  logic                     ref_clk,
    input  logic                     rst_n,
    input  logic                     ps_en,
    input  logic                     ps_up,
    output logic                     ps_done,
    output logic signed [STEP_W-1:0] step_val,
    output logic                     at_limit
);
    localparam int LIM = step_limit(CLK_PERIOD_PS, STEP_W);

    logic req_tgl;
    logic ack_tgl;
    logic apply;
    logic apply_up;
    logic busy;

    ps_req_ctrl u_ctrl (
        .clk      (ps_clk),
        .rst_n    (rst_n),
        .en       (ps_en),
        .dir      (ps_up),
        .ack_tgl  (ack_tgl),
        .req_tgl  (req_tgl),
        .apply    (apply),
        .apply_up (apply_up),
        .done     (ps_done),
        .busy     (busy)
    );

    ps_ref_delay #(.REF_LAT(REF_LAT)) u_delay (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .req_tgl (req_tgl),
        .ack_tgl (ack_tgl)
    );

    ps_step_acc #(.W(STEP_W), .LIM(LIM)) u_acc (
        .clk      (ps_clk),
        .rst_n    (rst_n),
        .apply    (apply),
        .up       (apply_up),
        .step     (step_val),
        .at_limit (at_limit)
    );

    // R4: a done pulse never appears while a request is still outstanding.
    p_done_when_idle_r4: assert property (@(posedge ps_clk) disable iff (!rst_n)
        ps_done |-> !busy || $past(ps_en));

endmodule

// File: tb/phase_step_unit_test.sv
// Bench for phase_step_unit: sweeps the step count to both bounds in two
// frequency bands and checks latency, pulse width, ignored enables and reset.
module phase_step_unit_test;

    localparam int P_HI   = 3400;   // 294 MHz band, bound 6
    localparam int LAT_HI = 8;
    localparam int P_LO   = 20000;  // 50 MHz band, bound 170
    localparam int LAT_LO = 3;
    localparam int W      = 10;

    logic ps_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 1'b0, up_a = 1'b0, en_b = 1'b0, up_b = 1'b0;
    logic done_a, done_b, lim_a, lim_b;
    logic signed [W-1:0] step_a, step_b;

    int checks = 0;
    int errors = 0;
    int done_cnt_a = 0;
    bit finished = 0;

    always #4 ps_clk = ~ps_clk;   // 125 MHz
    always #5 ref_clk = ~ref_clk; // 100 MHz

    phase_step_unit #(.CLK_PERIOD_PS(P_HI), .REF_LAT(LAT_HI), .STEP_W(W)) uut (
        .ps_clk(ps_clk), .ref_clk(ref_clk), .rst_n(rst_n), .ps_en(en_a), .ps_up(up_a),
        .ps_done(done_a), .step_val(step_a), .at_limit(lim_a));

    phase_step_unit #(.CLK_PERIOD_PS(P_LO), .REF_LAT(LAT_LO), .STEP_W(W)) uut_lo (
        .ps_clk(ps_clk), .ref_clk(ref_clk), .rst_n(rst_n), .ps_en(en_b), .ps_up(up_b),
        .ps_done(done_b), .step_val(step_b), .at_limit(lim_b));

    always @(negedge ps_clk) if (done_a === 1'b1) done_cnt_a++;

    function automatic int bound_of(input int p);
        if (p <= 3000) return 0;
        if (p * 60 > 1000000) return (10 * (p - 3000)) / 1000;
        return (15 * (p - 3000)) / 1000;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One request on uut; checks latency window, value, flag and pulse width.
    task automatic req_a(input bit d, input int exp_step, input int lim);
        int lat;
        int lo_b;
        int hi_b;
        lo_b = (LAT_HI * 10) / 8 + 3;
        hi_b = ((LAT_HI + 4) * 10) / 8 + 10;
        @(negedge ps_clk); en_a = 1'b1; up_a = d;
        @(negedge ps_clk); en_a = 1'b0;
        lat = 1;
        while (done_a !== 1'b1 && lat < 200) begin
            @(negedge ps_clk); lat++;
        end
        check(lat >= lo_b && lat <= hi_b, "R5 latency", lat, lo_b);
        check(int'(step_a) == exp_step, d ? "R1/R3 step" : "R2/R3 step", int'(step_a), exp_step);
        check(lim_a == ((exp_step == lim) || (exp_step == -lim)), "R8 at_limit", int'(lim_a), 0);
        @(negedge ps_clk);
        check(done_a == 1'b0, "R4 done width", int'(done_a), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lim_a_v;
        int lim_b_v;
        int exp;
        int base;
        lim_a_v = bound_of(P_HI);
        lim_b_v = bound_of(P_LO);

        repeat (6) @(negedge ps_clk);
        rst_n = 1'b1;
        @(negedge ps_clk);
        check(int'(step_a) == 0, "R7 reset step", int'(step_a), 0);
        check(done_a == 1'b0, "R7 reset done", int'(done_a), 0);
        check(int'(step_b) == 0, "R7 reset step lo", int'(step_b), 0);

        // R1 R3 R8: climb past the upper bound of the fast band.
        exp = 0;
        for (int i = 0; i < lim_a_v + 2; i++) begin
            if (exp < lim_a_v) exp++;
            req_a(1'b1, exp, lim_a_v);
        end
        // R2 R3 R8: descend past the lower bound.
        for (int i = 0; i < 2 * lim_a_v + 2; i++) begin
            if (exp > -lim_a_v) exp--;
            req_a(1'b0, exp, lim_a_v);
        end
        // Return to a mid value.
        for (int i = 0; i < lim_a_v; i++) begin
            exp++;
            req_a(1'b1, exp, lim_a_v);
        end

        // R6: enables during the wait are ignored.
        base = done_cnt_a;
        @(negedge ps_clk); en_a = 1'b1; up_a = 1'b1;
        @(negedge ps_clk); en_a = 1'b0;
        repeat (3) @(negedge ps_clk);
        en_a = 1'b1; up_a = 1'b0;
        @(negedge ps_clk); en_a = 1'b0;
        repeat (2) @(negedge ps_clk);
        en_a = 1'b1; up_a = 1'b1;
        @(negedge ps_clk); en_a = 1'b0;
        repeat (80) @(negedge ps_clk);
        check(done_cnt_a - base == 1, "R6 single done", done_cnt_a - base, 1);
        check(int'(step_a) == exp + 1, "R6 single step", int'(step_a), exp + 1);

        // R7: reset during a pending request.
        @(negedge ps_clk); en_a = 1'b1; up_a = 1'b1;
        @(negedge ps_clk); en_a = 1'b0;
        repeat (5) @(negedge ps_clk);
        rst_n = 1'b0;
        repeat (4) @(negedge ps_clk);
        rst_n = 1'b1;
        base = done_cnt_a;
        repeat (80) @(negedge ps_clk);
        check(done_cnt_a == base, "R7 no done after reset", done_cnt_a - base, 0);
        check(int'(step_a) == 0, "R7 step cleared", int'(step_a), 0);
        check(lim_a == 1'b0, "R8 flag cleared", int'(lim_a), 0);

        // R9 R3 R8: slow band, enable held high, one step per done.
        exp = 0;
        en_b = 1'b1; up_b = 1'b1;
        for (int i = 0; i < lim_b_v + 4; i++) begin
            int t;
            t = 0;
            @(negedge ps_clk);
            while (done_b !== 1'b1 && t < 100) begin @(negedge ps_clk); t++; end
            if (exp < lim_b_v) exp++;
            check(int'(step_b) == exp, "R9 held-enable step up", int'(step_b), exp);
        end
        check(lim_b == 1'b1, "R8 upper flag slow band", int'(lim_b), 1);
        up_b = 1'b0;
        for (int i = 0; i < 2 * lim_b_v + 4; i++) begin
            int t;
            t = 0;
            @(negedge ps_clk);
            while (done_b !== 1'b1 && t < 100) begin @(negedge ps_clk); t++; end
            if (exp > -lim_b_v) exp--;
            check(int'(step_b) == exp, "R9 held-enable step down", int'(step_b), exp);
        end
        check(lim_b == 1'b1 && int'(step_b) == -lim_b_v, "R3 lower bound slow band", int'(step_b), -lim_b_v);
        en_b = 1'b0;

        repeat (10) @(negedge ps_clk);
        finish_run();
    end

endmodule